// File: doc/BRIEF.md
# Block Address Translation Matcher

This block maps a 32-bit effective address to a real address using a small table of block translation entries. It holds two independent tables of eight entries, one for instruction fetches and one for data accesses, and a select input on each lookup picks which table is searched. Each entry describes one aligned block. It holds a base effective address, a mask that picks which address bits must match, a base real address, one enable bit for user mode, one enable bit for supervisor mode, and a two-bit protection code.

Software loads entries through a one-cycle write port that replaces a whole entry at once. A lookup presents the address, the table select, a user-mode flag and a write flag. One clock later the block returns hit or miss, the translated address and the read, write and execute permissions. Every entry is compared in parallel. The lowest-index entry that qualifies supplies the result. An entry that matches but refuses the access is passed over, and the search continues with the entries above it.

Top module: `bat_xlate`

## Requirements
- R1: Reset disables every entry in both tables, so a lookup issued after reset misses for any address, mode and table, even though the cleared entries have a zero mask and a zero base.
- R2: `lkData`=1 searches only the data table and `lkData`=0 searches only the instruction table. `wrBank`=1 writes the data table and `wrBank`=0 writes the instruction table, and the two tables never affect each other.
- R3: When `lkUser`=1, an entry takes part only if its user enable bit is set. When `lkUser`=0, it takes part only if its supervisor enable bit is set.
- R4: An entry matches when (`lkAddr` AND mask) equals its stored effective base.
- R5: On a hit, `resAddr` is the entry's real base ORed with the address bits that the entry's mask clears.
- R6: An entry whose protection code is 0 grants no read access. It is passed over even when it matches, and a later qualifying entry can still hit.
- R7: On a write lookup (`lkWrite`=1), a matching entry with protection code 1 is passed over. On a read lookup the same entry hits with `resWrite`=0.
- R8: On a hit, `resRead`=1 and `resExec`=1, and `resWrite`=1 exactly when the protection code is 2 or 3.
- R9: When several entries qualify, the one with the lowest index supplies the result.
- R10: On a miss, `resHit`, `resRead`, `resWrite` and `resExec` are 0 and `resAddr` is 0.
- R11: A lookup presented at a rising clock edge produces `resValid`=1 with its result after that edge. In a cycle with no lookup, `resValid` is 0 after the next edge.
- R12: A lookup issued in the same cycle as a write to a matching entry sees the table as it was before that write. The next lookup sees the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write one entry this cycle |
| wrBank | input | 1 | Table to write: 1 data, 0 instruction |
| wrIdx | input | 3 | Entry index to write |
| wrEffBase | input | 32 | Effective block base |
| wrMask | input | 32 | Block mask, 1 bits are compared |
| wrRealBase | input | 32 | Real block base |
| wrUserOk | input | 1 | Entry enabled in user mode |
| wrSupOk | input | 1 | Entry enabled in supervisor mode |
| wrProt | input | 2 | Protection code: 0 none, 1 read, 2 or 3 read/write |
| lkValid | input | 1 | Lookup request |
| lkAddr | input | 32 | Effective address to translate |
| lkData | input | 1 | Table to search: 1 data, 0 instruction |
| lkUser | input | 1 | Requester is in user mode |
| lkWrite | input | 1 | Access is a write |
| resValid | output | 1 | Result below is for the previous cycle's lookup |
| resHit | output | 1 | An entry qualified |
| resAddr | output | 32 | Translated real address |
| resRead | output | 1 | Read allowed |
| resWrite | output | 1 | Write allowed |
| resExec | output | 1 | Execute allowed |

## Verification
Overlapping entries are loaded so that one address matches a read-only entry at index 0 and a read/write entry at index 1. A read and a write lookup to that address then separate lowest-index priority from skip-on-deny. A second address is covered by a zero-protection entry and by a user-only entry, so the user and supervisor lookups show both the skip of the non-readable entry and the gating by mode enable bits. The same address is tried against both tables to show that they are kept apart. A write and a lookup in the same cycle, followed by a repeat of the lookup, pin down which table contents a lookup sees.

// File: rtl/bat_pkg.sv
package bat_pkg;
  parameter int ADDR_W      = 32;
  parameter int NUM_ENTRIES = 8;
  parameter int PROT_W      = 2;
  localparam int IDX_W      = $clog2(NUM_ENTRIES);

  typedef struct packed {
    logic [ADDR_W-1:0] effBase;
    logic [ADDR_W-1:0] mask;
    logic [ADDR_W-1:0] realBase;
    logic              userOk;
    logic              supOk;
    logic [PROT_W-1:0] prot;
  } batEntry_t;

  typedef struct packed {
    logic wrInstr;
    logic wrData;
    logic lookup;
  } batStrobe_t;

  typedef struct packed {
    logic              hit;
    logic [ADDR_W-1:0] realAddr;
    logic              rd;
    logic              wr;
    logic              ex;
  } batResult_t;
endpackage

// File: rtl/bat_ctrl.sv
module bat_ctrl
  import bat_pkg::*;
(
  input  logic       wrEn,
  input  logic       wrBank,
  input  logic       lkValid,
  output batStrobe_t strobe
);
  always_comb begin
    strobe.wrInstr = wrEn && !wrBank;
    strobe.wrData  = wrEn &&  wrBank;
    strobe.lookup  = lkValid;
  end
endmodule

// File: rtl/bat_dp.sv
module bat_dp
  import bat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  batStrobe_t        strobe,
  input  logic [IDX_W-1:0]  wrIdx,
  input  batEntry_t         wrEntry,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkData,
  input  logic              lkUser,
  input  logic              lkWrite,
  output logic              resValid,
  output batResult_t        result
);
  batEntry_t instrTab [NUM_ENTRIES];
  batEntry_t dataTab  [NUM_ENTRIES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        instrTab[e] <= '0;
        dataTab[e]  <= '0;
      end
    end else begin
      if (strobe.wrInstr) instrTab[wrIdx] <= wrEntry;
      if (strobe.wrData)  dataTab[wrIdx]  <= wrEntry;
    end
  end

  batEntry_t              selEntry [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] qualVec;

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic enabled, addrMatch, readOk, writeOk;
    assign selEntry[e] = lkData ? dataTab[e] : instrTab[e];
    assign enabled     = lkUser ? selEntry[e].userOk : selEntry[e].supOk;
    assign addrMatch   = (lkAddr & selEntry[e].mask) == selEntry[e].effBase;
    assign readOk      = selEntry[e].prot != '0;
    assign writeOk     = selEntry[e].prot > PROT_W'(1);
    assign qualVec[e]  = enabled && addrMatch && readOk && (!lkWrite || writeOk);
  end

  logic [IDX_W-1:0] winIdx;
  logic             anyQual;
  always_comb begin
    winIdx  = '0;
    anyQual = 1'b0;
    for (int e = NUM_ENTRIES - 1; e >= 0; e--) begin
      if (qualVec[e]) begin
        winIdx  = IDX_W'(e);
        anyQual = 1'b1;
      end
    end
  end

  batResult_t nextRes;
  always_comb begin
    nextRes = '0;
    if (anyQual) begin
      nextRes.hit      = 1'b1;
      nextRes.realAddr = selEntry[winIdx].realBase | (lkAddr & ~selEntry[winIdx].mask);
      nextRes.rd       = 1'b1;
      nextRes.wr       = selEntry[winIdx].prot > PROT_W'(1);
      nextRes.ex       = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      result   <= '0;
    end else begin
      resValid <= strobe.lookup;
      result   <= strobe.lookup ? nextRes : '0;
    end
  end
endmodule

// File: rtl/bat_xlate.sv
module bat_xlate
  import bat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              wrBank,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [ADDR_W-1:0] wrEffBase,
  input  logic [ADDR_W-1:0] wrMask,
  input  logic [ADDR_W-1:0] wrRealBase,
  input  logic              wrUserOk,
  input  logic              wrSupOk,
  input  logic [PROT_W-1:0] wrProt,
  input  logic              lkValid,
  input  logic [ADDR_W-1:0] lkAddr,
  input  logic              lkData,
  input  logic              lkUser,
  input  logic              lkWrite,
  output logic              resValid,
  output logic              resHit,
  output logic [ADDR_W-1:0] resAddr,
  output logic              resRead,
  output logic              resWrite,
  output logic              resExec
);
  batStrobe_t strobe;
  batEntry_t  wrEntry;
  batResult_t result;

  assign wrEntry = '{effBase: wrEffBase, mask: wrMask, realBase: wrRealBase,
                     userOk: wrUserOk, supOk: wrSupOk, prot: wrProt};

  bat_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrBank  (wrBank),
    .lkValid (lkValid),
    .strobe  (strobe)
  );

  bat_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrIdx    (wrIdx),
    .wrEntry  (wrEntry),
    .lkAddr   (lkAddr),
    .lkData   (lkData),
    .lkUser   (lkUser),
    .lkWrite  (lkWrite),
    .resValid (resValid),
    .result   (result)
  );

  assign resHit   = result.hit;
  assign resAddr  = result.realAddr;
  assign resRead  = result.rd;
  assign resWrite = result.wr;
  assign resExec  = result.ex;
endmodule

// File: rtl/bat_xlate_chk.sv
module bat_xlate_chk
  import bat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic              lkWrite,
  input logic              resValid,
  input logic              resHit,
  input logic [ADDR_W-1:0] resAddr,
  input logic              resRead,
  input logic              resWrite,
  input logic              resExec
);
  AST_HIT_READ_EXEC: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resHit |-> resRead && resExec); // R8

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resHit |-> resAddr == '0 && !resRead && !resWrite && !resExec); // R10

  AST_LOOKUP_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |=> resValid); // R11

  AST_IDLE_NO_RESULT: assert property (@(posedge clk) disable iff (!rstN)
    !lkValid |=> !resValid); // R11

  AST_WRITE_HIT_WRITABLE: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resHit && $past(lkWrite) |-> resWrite); // R7
endmodule

bind bat_xlate bat_xlate_chk u_chk (.*);

// File: tb/bat_xlate_tb.sv
module bat_xlate_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrBank = 1'b0;
  logic [2:0]  wrIdx = '0;
  logic [31:0] wrEffBase = '0, wrMask = '0, wrRealBase = '0;
  logic        wrUserOk = 1'b0, wrSupOk = 1'b0;
  logic [1:0]  wrProt = '0;
  logic        lkValid = 1'b0;
  logic [31:0] lkAddr = '0;
  logic        lkData = 1'b0, lkUser = 1'b0, lkWrite = 1'b0;
  logic        resValid, resHit, resRead, resWrite, resExec;
  logic [31:0] resAddr;

  always #5 clk = ~clk;

  bat_xlate u_dut (.*);

  typedef struct {
    logic        hit;
    logic [31:0] addr;
    logic        rd, wr, ex;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic putEntry(input logic bank, input logic [2:0] idx, input logic [31:0] base,
                          input logic [31:0] mask, input logic [31:0] rbase,
                          input logic u, input logic s, input logic [1:0] prot);
    wrEn = 1'b1; wrBank = bank; wrIdx = idx; wrEffBase = base; wrMask = mask;
    wrRealBase = rbase; wrUserOk = u; wrSupOk = s; wrProt = prot;
  endtask

  task automatic writeEntry(input logic bank, input logic [2:0] idx, input logic [31:0] base,
                            input logic [31:0] mask, input logic [31:0] rbase,
                            input logic u, input logic s, input logic [1:0] prot);
    @(negedge clk);
    lkValid = 1'b0;
    putEntry(bank, idx, base, mask, rbase, u, s, prot);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Drives a lookup for the coming edge and queues what it must return.
  task automatic issue(input logic [31:0] addr, input logic dsel, input logic usr,
                       input logic wrt, input logic eHit, input logic [31:0] eAddr,
                       input logic eWr, input string tag);
    expItem_t it;
    lkValid = 1'b1; lkAddr = addr; lkData = dsel; lkUser = usr; lkWrite = wrt;
    it.hit = eHit; it.addr = eHit ? eAddr : 32'h0;
    it.rd = eHit; it.wr = eHit && eWr; it.ex = eHit; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic look(input logic [31:0] addr, input logic dsel, input logic usr,
                      input logic wrt, input logic eHit, input logic [31:0] eAddr,
                      input logic eWr, input string tag);
    @(negedge clk);
    issue(addr, dsel, usr, wrt, eHit, eAddr, eWr, tag);
  endtask

  task automatic idle();
    @(negedge clk);
    lkValid = 1'b0;
  endtask

  // Monitor: compares each result against the oldest queued expectation.
  always @(negedge clk) begin
    if (rstN && resValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R11 result without lookup: actual resValid=1 expected 0");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        if (resHit !== e.hit || resAddr !== e.addr || resRead !== e.rd ||
            resWrite !== e.wr || resExec !== e.ex) begin
          failures++;
          $display("FAIL %s: actual hit=%b addr=%h r=%b w=%b x=%b expected hit=%b addr=%h r=%b w=%b x=%b",
                   e.tag, resHit, resAddr, resRead, resWrite, resExec,
                   e.hit, e.addr, e.rd, e.wr, e.ex);
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual run still busy expected finished");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0 || resHit !== 1'b0 || resAddr !== 32'h0) begin
      failures++;
      $display("FAIL R1 reset outputs: actual valid=%b hit=%b addr=%h expected 0 0 0",
               resValid, resHit, resAddr);
    end
    // R1: zero mask/base entries would match anything if still enabled
    look(32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "R1 data sup");
    look(32'h1234_5678, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R1 instr user");
    idle();

    writeEntry(1'b1, 3'd0, 32'h1000_0000, 32'hF000_0000, 32'h8000_0000, 1'b1, 1'b1, 2'd1);
    writeEntry(1'b1, 3'd1, 32'h1000_0000, 32'hFF00_0000, 32'h4000_0000, 1'b1, 1'b1, 2'd2);
    writeEntry(1'b1, 3'd2, 32'h2000_0000, 32'hF000_0000, 32'h5000_0000, 1'b0, 1'b1, 2'd3);
    writeEntry(1'b1, 3'd3, 32'h3000_0000, 32'hF000_0000, 32'h6000_0000, 1'b1, 1'b1, 2'd0);
    writeEntry(1'b1, 3'd4, 32'h3000_0000, 32'hF000_0000, 32'h7000_0000, 1'b1, 1'b0, 2'd2);
    writeEntry(1'b0, 3'd0, 32'h1000_0000, 32'hF000_0000, 32'hA000_0000, 1'b1, 1'b1, 2'd2);

    // Back-to-back lookups (R11)
    look(32'h1012_3456, 1'b1, 1'b0, 1'b0, 1'b1, 32'h8012_3456, 1'b0, "R9 R5 lowest index read");
    look(32'h1012_3456, 1'b1, 1'b0, 1'b1, 1'b1, 32'h4012_3456, 1'b1, "R7 read-only skipped on write");
    look(32'h1112_3456, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0,         1'b0, "R4 R10 mask mismatch miss");
    look(32'h2000_0010, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, "R3 user bit clear");
    look(32'h2000_0010, 1'b1, 1'b0, 1'b0, 1'b1, 32'h5000_0010, 1'b1, "R3 R8 supervisor prot3");
    look(32'h3ABC_0000, 1'b1, 1'b1, 1'b0, 1'b1, 32'h7ABC_0000, 1'b1, "R6 prot0 skipped");
    look(32'h3ABC_0000, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, "R6 R3 prot0 then sup bit clear");
    look(32'h1012_3456, 1'b0, 1'b0, 1'b1, 1'b1, 32'hA012_3456, 1'b1, "R2 instruction table");
    look(32'h2000_0010, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,         1'b0, "R2 data entry unseen");
    look(32'h4000_0000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0,         1'b0, "R4 no base match");
    idle();
    @(negedge clk);
    checks++;
    if (resValid !== 1'b0) begin
      failures++;
      $display("FAIL R11 idle cycle: actual resValid=%b expected 0", resValid);
    end

    // R12: write and lookup in the same cycle
    @(negedge clk);
    putEntry(1'b1, 3'd5, 32'h5000_0000, 32'hF000_0000, 32'h9000_0000, 1'b1, 1'b1, 2'd2);
    issue(32'h5000_0044, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "R12 same-cycle sees old table");
    @(negedge clk);
    wrEn = 1'b0;
    issue(32'h5000_0044, 1'b1, 1'b0, 1'b0, 1'b1, 32'h9000_0044, 1'b1, "R12 next lookup sees entry");
    idle();
    repeat (3) @(negedge clk);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R11 missing results: actual pending=%0d expected 0", expQ.size());
    end
    finish();
  end
endmodule